// File: doc/BRIEF.md
# Aliased Single/Double Floating-Point Register File

This block holds the floating-point architectural state of a processor core. It is one array of thirty-two 32-bit words, and it can be addressed in two ways. A 32-bit access reaches one word. A 64-bit access reaches an aligned pair of words that overlaps the same storage. Nothing is copied between the two views, so a value written in one precision is seen at once through the other.

There are two combinational read ports and one synchronous write port. Each port has its own precision select. A 64-bit access must name an even index. An odd index raises a per-port misalignment flag: on a read the data bus is forced to zero, and on a write the array is left untouched.

The block only stores and addresses data. It does no arithmetic and keeps no tags. Register zero is an ordinary register, not a constant. A synchronous, active-high reset clears every word.

Top module: `fprf_aliased`

## Requirements
- R1: A clock edge with `rst` high sets all 32 words to zero, and every read after it returns zero.
- R2: A 32-bit write (`wr_dbl`=0) changes only the word named by `wr_idx`. A 32-bit read returns that word in bits [31:0] of the read data, with bits [63:32] at zero.
- R3: A 64-bit write (`wr_dbl`=1) to an even index 2k updates both words in the same edge: word 2k takes `wr_data[63:32]` and word 2k+1 takes `wr_data[31:0]`.
- R4: A 64-bit read at an even index 2k returns {word 2k, word 2k+1}, with word 2k in bits [63:32].
- R5: The two views share storage. Words written by 32-bit writes are visible through 64-bit reads, and halves written by 64-bit writes are visible through 32-bit reads.
- R6: A 64-bit read at an odd index raises that port's misalignment flag and drives its data to zero. A 32-bit read never raises the flag.
- R7: A 64-bit write at an odd index with `wr_en`=1 raises `wr_misalign` and leaves all 32 words unchanged.
- R8: A read of a word that is being written in the same cycle returns the old contents until the edge. This holds per 32-bit word when precisions are mixed.
- R9: The two read ports are independent. Each can use a different index and precision in the same cycle.
- R10: Word 0 is an ordinary register. It stores and returns any written value.
- R11: With `wr_en`=0 the array does not change, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the array |
| wr_en | input | 1 | Write request |
| wr_dbl | input | 1 | Write precision: 1 = 64-bit pair, 0 = 32-bit word |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data; only [31:0] is used for 32-bit writes |
| wr_misalign | output | 1 | Odd-index 64-bit write requested (write dropped) |
| rd0_dbl | input | 1 | Port 0 precision |
| rd0_idx | input | 5 | Port 0 register index |
| rd0_data | output | 64 | Port 0 read data |
| rd0_misalign | output | 1 | Port 0 odd-index 64-bit read |
| rd1_dbl | input | 1 | Port 1 precision |
| rd1_idx | input | 5 | Port 1 register index |
| rd1_data | output | 64 | Port 1 read data |
| rd1_misalign | output | 1 | Port 1 odd-index 64-bit read |

## Verification
The reads are combinational, so a wrong word enable or a swapped half shows up on the read bus in the first cycle after the faulty edge. The bench reads that word back at once through either view.
A write that spills into the next pair, or an odd-index write that is not dropped, corrupts a word next to the target. For that reason the bench compares the whole array against its own model after each scenario, rather than reading only the target.
A write-through path would show before the edge, so each same-cycle overlap is sampled in the middle of the write cycle and again after the edge.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
    parameter int unsigned FPRF_WORD_W    = 32;
    parameter int unsigned FPRF_NUM_WORDS = 32;
endpackage

// File: rtl/fprf_wr_dec.sv
module fprf_wr_dec #(
    parameter int unsigned WORD_W    = fprf_pkg::FPRF_WORD_W,
    parameter int unsigned NUM_WORDS = fprf_pkg::FPRF_NUM_WORDS,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
    localparam int unsigned PAIR_W   = IDX_W - 1
) (
    input  logic                                wr_en,
    input  logic                                wr_dbl,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [2*WORD_W-1:0]                 wr_data,
    output logic [NUM_WORDS-1:0]                word_we,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]    word_wd,
    output logic                                bad_align
);
    logic odd_pair;
    assign odd_pair  = wr_dbl & wr_idx[0];
    assign bad_align = wr_en & odd_pair;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [PAIR_W-1:0] PAIR   = PAIR_W'(i / 2);
        localparam bit                IS_TOP = (i % 2) == 0;
        logic hit_sgl;
        logic hit_dbl;
        assign hit_sgl = !wr_dbl && (wr_idx == IDX_W'(i));
        assign hit_dbl = wr_dbl && !wr_idx[0] && (wr_idx[IDX_W-1:1] == PAIR);
        assign word_we[i] = wr_en & (hit_sgl | hit_dbl);
        if (IS_TOP) begin : g_top
            assign word_wd[i] = wr_dbl ? wr_data[2*WORD_W-1:WORD_W] : wr_data[WORD_W-1:0];
        end else begin : g_bot
            assign word_wd[i] = wr_data[WORD_W-1:0];
        end
    end
endmodule

// File: rtl/fprf_bank.sv
module fprf_bank #(
    parameter int unsigned WORD_W    = fprf_pkg::FPRF_WORD_W,
    parameter int unsigned NUM_WORDS = fprf_pkg::FPRF_NUM_WORDS
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_WORDS-1:0]             word_we,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] word_wd,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] words
);
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_cell
        logic [WORD_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (word_we[i]) begin
                cell_q <= word_wd[i];
            end
        end
        assign words[i] = cell_q;
    end
endmodule

// File: rtl/fprf_rd_port.sv
module fprf_rd_port #(
    parameter int unsigned WORD_W    = fprf_pkg::FPRF_WORD_W,
    parameter int unsigned NUM_WORDS = fprf_pkg::FPRF_NUM_WORDS,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
    input  logic                             rd_dbl,
    input  logic [IDX_W-1:0]                 rd_idx,
    output logic [2*WORD_W-1:0]              rd_data,
    output logic                             rd_misalign
);
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  bot_idx;
    logic [WORD_W-1:0] top_word;
    logic [WORD_W-1:0] bot_word;

    assign top_idx     = {rd_idx[IDX_W-1:1], 1'b0};
    assign bot_idx     = {rd_idx[IDX_W-1:1], 1'b1};
    assign top_word    = words[top_idx];
    assign bot_word    = words[bot_idx];
    assign rd_misalign = rd_dbl & rd_idx[0];

    always_comb begin
        if (rd_misalign) begin
            rd_data = '0;
        end else if (rd_dbl) begin
            rd_data = {top_word, bot_word};
        end else begin
            rd_data = {{WORD_W{1'b0}}, words[rd_idx]};
        end
    end
endmodule

// File: rtl/fprf_aliased.sv
module fprf_aliased #(
    parameter int unsigned WORD_W    = fprf_pkg::FPRF_WORD_W,
    parameter int unsigned NUM_WORDS = fprf_pkg::FPRF_NUM_WORDS,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_dbl,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [2*WORD_W-1:0] wr_data,
    output logic                wr_misalign,
    input  logic                rd0_dbl,
    input  logic [IDX_W-1:0]    rd0_idx,
    output logic [2*WORD_W-1:0] rd0_data,
    output logic                rd0_misalign,
    input  logic                rd1_dbl,
    input  logic [IDX_W-1:0]    rd1_idx,
    output logic [2*WORD_W-1:0] rd1_data,
    output logic                rd1_misalign
);
    logic [NUM_WORDS-1:0]             word_we;
    logic [NUM_WORDS-1:0][WORD_W-1:0] word_wd;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;

    fprf_wr_dec #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_wr_dec (
        .wr_en     (wr_en),
        .wr_dbl    (wr_dbl),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .word_we   (word_we),
        .word_wd   (word_wd),
        .bad_align (wr_misalign)
    );

    fprf_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .word_we (word_we),
        .word_wd (word_wd),
        .words   (words)
    );

    fprf_rd_port #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_rd0 (
        .words       (words),
        .rd_dbl      (rd0_dbl),
        .rd_idx      (rd0_idx),
        .rd_data     (rd0_data),
        .rd_misalign (rd0_misalign)
    );

    fprf_rd_port #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_rd1 (
        .words       (words),
        .rd_dbl      (rd1_dbl),
        .rd_idx      (rd1_idx),
        .rd_data     (rd1_data),
        .rd_misalign (rd1_misalign)
    );
endmodule

// File: rtl/fprf_aliased_chk.sv
module fprf_aliased_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                wr_dbl,
    input logic [IDX_W-1:0]    wr_idx,
    input logic [2*WORD_W-1:0] wr_data,
    input logic                wr_misalign,
    input logic                rd0_dbl,
    input logic [IDX_W-1:0]    rd0_idx,
    input logic [2*WORD_W-1:0] rd0_data,
    input logic                rd0_misalign,
    input logic                rd1_dbl,
    input logic [IDX_W-1:0]    rd1_idx,
    input logic [2*WORD_W-1:0] rd1_data
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rd0_data == '0 && rd1_data == '0)); // R1

    AST_SGL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd1_dbl |-> rd1_data[2*WORD_W-1:WORD_W] == '0); // R2

    AST_DBL_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dbl && !wr_idx[0] && rd0_dbl && rd0_idx == wr_idx)
        |=> (!($stable(rd0_idx) && $stable(rd0_dbl)) || rd0_data == $past(wr_data))); // R3

    AST_MISALIGN_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        rd0_misalign |-> (rd0_data == '0 && rd0_dbl)); // R6

    AST_BAD_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        wr_misalign |=> (!($stable(rd1_idx) && $stable(rd1_dbl)) || $stable(rd1_data))); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (!($stable(rd0_idx) && $stable(rd0_dbl)) || $stable(rd0_data))); // R11
endmodule

bind fprf_aliased fprf_aliased_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_dbl       (wr_dbl),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .wr_misalign  (wr_misalign),
    .rd0_dbl      (rd0_dbl),
    .rd0_idx      (rd0_idx),
    .rd0_data     (rd0_data),
    .rd0_misalign (rd0_misalign),
    .rd1_dbl      (rd1_dbl),
    .rd1_idx      (rd1_idx),
    .rd1_data     (rd1_data)
);

// File: tb/tb_fprf_aliased.sv
`timescale 1ns/1ps
module tb_fprf_aliased;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_dbl = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_misalign;
    logic        rd0_dbl = 1'b0, rd1_dbl = 1'b0;
    logic [4:0]  rd0_idx = '0, rd1_idx = '0;
    logic [63:0] rd0_data, rd1_data;
    logic        rd0_misalign, rd1_misalign;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [32];

    always #2.5 clk = ~clk;

    fprf_aliased dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_misalign(wr_misalign),
        .rd0_dbl(rd0_dbl), .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd0_misalign(rd0_misalign),
        .rd1_dbl(rd1_dbl), .rd1_idx(rd1_idx), .rd1_data(rd1_data), .rd1_misalign(rd1_misalign)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write(input logic dbl, input logic [4:0] idx, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_dbl = dbl; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        logic bad = 1'b0;
        for (int i = 0; i < 32; i++) begin
            rd1_dbl = 1'b0; rd1_idx = 5'(i);
            #0.1;
            if (rd1_data !== {32'h0, model[i]}) begin
                bad = 1'b1;
                $display("FAIL %s word %0d actual=%h expected=%h", req, i, rd1_data, {32'h0, model[i]});
            end
        end
        checks++;
        if (bad) errors++;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 32; i++) model[i] = '0;
        for (int p = 0; p < 16; p++) begin
            rd0_dbl = 1'b1; rd0_idx = 5'(2 * p);
            #0.1;
            chk("R1 dbl read after reset", rd0_data, 64'h0);
        end
        check_all("R1 all words zero");
    endtask

    task automatic t_single;
        write(1'b0, 5'd0, 64'hFFFF_FFFF_A5A5_0001);
        model[0] = 32'hA5A5_0001;
        write(1'b0, 5'd7, 64'h0000_0000_0BAD_F00D);
        model[7] = 32'h0BAD_F00D;
        rd0_dbl = 1'b0; rd0_idx = 5'd0; #0.1;
        chk("R10 word 0 holds value", rd0_data, 64'h0000_0000_A5A5_0001);
        chk("R2 upper bits zero on single read", {32'h0, rd0_data[63:32]}, 64'h0);
        check_all("R2 only addressed words changed");
    endtask

    task automatic t_double;
        write(1'b1, 5'd4, 64'h1111_2222_3333_4444);
        model[4] = 32'h1111_2222; model[5] = 32'h3333_4444;
        rd0_dbl = 1'b0; rd0_idx = 5'd4; #0.1;
        chk("R3 R5 upper half in even word", rd0_data, 64'h0000_0000_1111_2222);
        rd0_idx = 5'd5; #0.1;
        chk("R3 R5 lower half in odd word", rd0_data, 64'h0000_0000_3333_4444);
        rd0_dbl = 1'b1; rd0_idx = 5'd4; #0.1;
        chk("R4 double read order", rd0_data, 64'h1111_2222_3333_4444);
        chk("R6 aligned read no flag", {63'h0, rd0_misalign}, 64'h0);
        check_all("R3 neighbours untouched");
    endtask

    task automatic t_sgl_into_dbl;
        write(1'b0, 5'd9, 64'h0000_0000_CAFE_0009);
        model[9] = 32'hCAFE_0009;
        write(1'b0, 5'd8, 64'h0000_0000_BEEF_0008);
        model[8] = 32'hBEEF_0008;
        rd1_dbl = 1'b1; rd1_idx = 5'd8; #0.1;
        chk("R5 singles seen as double", rd1_data, 64'hBEEF_0008_CAFE_0009);
    endtask

    task automatic t_misalign_read;
        rd0_dbl = 1'b1; rd0_idx = 5'd5; rd1_dbl = 1'b0; rd1_idx = 5'd5; #0.1;
        chk("R6 odd double read flag", {63'h0, rd0_misalign}, 64'h1);
        chk("R6 odd double read data zero", rd0_data, 64'h0);
        chk("R6 single read no flag", {63'h0, rd1_misalign}, 64'h0);
        chk("R9 other port still reads word", rd1_data, {32'h0, model[5]});
    endtask

    task automatic t_misalign_write;
        @(negedge clk);
        wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd5; wr_data = 64'hDEAD_DEAD_DEAD_DEAD;
        #0.1;
        chk("R7 odd double write flag", {63'h0, wr_misalign}, 64'h1);
        @(negedge clk);
        wr_en = 1'b0;
        #0.1;
        chk("R7 flag low when idle", {63'h0, wr_misalign}, 64'h0);
        check_all("R7 odd double write dropped");
    endtask

    task automatic t_rdw;
        @(negedge clk);
        wr_en = 1'b1; wr_dbl = 1'b0; wr_idx = 5'd10; wr_data = 64'h0000_0000_1234_5678;
        rd0_dbl = 1'b0; rd0_idx = 5'd10;
        #0.5;
        chk("R8 single read during write sees old", rd0_data, 64'h0);
        @(negedge clk);
        wr_en = 1'b0; model[10] = 32'h1234_5678;
        chk("R8 single read after edge sees new", rd0_data, 64'h0000_0000_1234_5678);
        wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd10; wr_data = 64'hAAAA_0001_BBBB_0002;
        rd0_dbl = 1'b0; rd0_idx = 5'd10; rd1_dbl = 1'b0; rd1_idx = 5'd11;
        #0.5;
        chk("R8 mixed overlap even word old", rd0_data, 64'h0000_0000_1234_5678);
        chk("R8 mixed overlap odd word old", rd1_data, 64'h0);
        @(negedge clk);
        wr_en = 1'b0; model[10] = 32'hAAAA_0001; model[11] = 32'hBBBB_0002;
        chk("R8 mixed overlap even word new", rd0_data, 64'h0000_0000_AAAA_0001);
        chk("R8 mixed overlap odd word new", rd1_data, 64'h0000_0000_BBBB_0002);
    endtask

    task automatic t_two_ports;
        write(1'b1, 5'd30, 64'h7777_8888_9999_AAAA);
        model[30] = 32'h7777_8888; model[31] = 32'h9999_AAAA;
        rd0_dbl = 1'b1; rd0_idx = 5'd30; rd1_dbl = 1'b0; rd1_idx = 5'd7; #0.1;
        chk("R9 port0 double top pair", rd0_data, 64'h7777_8888_9999_AAAA);
        chk("R9 port1 single concurrent", rd1_data, 64'h0000_0000_0BAD_F00D);
    endtask

    task automatic t_idle;
        @(negedge clk);
        wr_en = 1'b0; wr_dbl = 1'b1; wr_idx = 5'd0; wr_data = 64'h5555_5555_5555_5555;
        @(negedge clk);
        @(negedge clk);
        wr_dbl = 1'b0; wr_idx = 5'd3;
        @(negedge clk);
        check_all("R11 no write when disabled");
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        rd0_dbl = 1'b1; rd0_idx = 5'd30; #0.1;
        chk("R1 reset clears written pair", rd0_data, 64'h0);
        check_all("R1 reset clears all");
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_single;
        t_double;
        t_sgl_into_dbl;
        t_misalign_read;
        t_misalign_write;
        t_rdw;
        t_two_ports;
        t_idle;
        t_reset_again;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule